// File: doc/BRIEF.md
# Bus Clock-Run Stop Controller

This block decides, for a bus bridge, whether the primary bus clock may be stopped and when the secondary bus clock is gated off or brought back. The central resource asks for a primary clock stop by letting the open-drain clock-run line float high. The block either leaves the line alone, which grants the stop, or pulls it low for a short burst, which refuses it. A refusal is made again each time the line rises anew while the bridge is still busy or software has asked for the clock to stay on.

On the secondary side the block holds a clock gate. Two stop policies exist. In the following policy, the secondary clock is gated only after the primary stop has been granted. In the local policy, it is gated once the secondary bus is quiet, whatever the primary clock is doing. Either way, gating waits for a minimum run of quiet cycles. The clock comes back at once when the primary side has a downstream transaction pending, or when a secondary device pulls its clock-run line low.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset `pri_clkrun_oe` is 0, `sec_clk_en` is 1 and `sec_wake` is 0.
- R2: While `ctrl_byte[3]` (primary participation) is 0, `pri_clkrun_oe` stays 0 whatever the line does.
- R3: A stop request is a low-to-high change of `pri_clkrun_in`, where 1 means released. If the request arrives with `pri_idle`=1, `pri_req_pend`=0 and `ctrl_byte[2]`=0, it is granted and the line is not driven.
- R4: A refused request makes `pri_clkrun_oe` 1 for exactly DRIVE_CYC cycles (default 2), starting the cycle after the request is sampled. A request is refused when `pri_idle`=0 or `pri_req_pend`=1.
- R5: With `ctrl_byte[2]` (keep running) set, every stop request is refused.
- R6: After the drive is released, a new rise of the line is evaluated again, and is refused again if the refusal condition still holds.
- R7: With `ctrl_byte[0]`=0 (following policy), the secondary clock is gated only while a granted primary stop is in force. A grant lasts until the line reads 0.
- R8: With `ctrl_byte[0]`=1 (local policy), the secondary clock is gated on secondary quiet alone, with the primary clock running.
- R9: `pri_req_pend`=1 ungates the secondary clock on the next cycle.
- R10: `sec_clkrun_in`=0 while gated raises `sec_wake` in the same cycle, and ungates the clock on the next cycle.
- R11: While `ctrl_byte[1]` (secondary participation) is 0, `sec_clk_en` is 1, taking effect in the same cycle.
- R12: Quiet means `sec_idle`=1, `pri_req_pend`=0 and `sec_clkrun_in`=1. Gating happens only at the clock edge after IDLE_MIN (default 4) consecutive quiet edges, and that edge must also be quiet. Any non-quiet cycle restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_byte | input | 8 | Control byte: bit 3 primary enable, bit 2 keep running, bit 1 secondary enable, bit 0 local stop policy |
| pri_idle | input | 1 | Primary side has no transaction in flight |
| pri_req_pend | input | 1 | Downstream request pending from the primary side |
| sec_idle | input | 1 | Secondary bus idle |
| pri_clkrun_in | input | 1 | Sampled primary clock-run line (1 = released) |
| sec_clkrun_in | input | 1 | Sampled secondary clock-run line (0 = asserted by a device) |
| pri_clkrun_oe | output | 1 | Pull the primary clock-run line low |
| sec_clk_en | output | 1 | Secondary clock gate enable (1 = clock runs) |
| sec_wake | output | 1 | Secondary clock-run assertion sensed while gated |

## Verification
The bench refuses a request while the primary side is busy. It checks that the drive ends after exactly two cycles, and that the line rising again is refused a second time. A design that latched its refusal, or that detected only the first edge, would hang the line low or grant a stop mid-transaction. In both policies the bench counts the quiet run to the edge, breaks it with a pending request, and checks that gating waits a full fresh run. A design off by one in the idle count, or one that forgot to clear it, would gate a cycle early or too soon after activity. The bench also clears the enable bits while the clock is gated and while refusal is pending, which catches a gate or drive that lingers past disable.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   // Control byte bit positions: software writes this layout.
   localparam int CR_LOCAL_BIT  = 0;
   localparam int CR_SEC_EN_BIT = 1;
   localparam int CR_KEEP_BIT   = 2;
   localparam int CR_PRI_EN_BIT = 3;
   localparam int CR_WIDTH      = 8;

   typedef struct packed {
      logic pri_en;
      logic keep_run;
      logic sec_en;
      logic local_stop;
   } cr_ctrl_t;

   typedef enum logic {
      SG_RUN   = 1'b0,
      SG_GATED = 1'b1
   } sg_state_e;

   function automatic cr_ctrl_t cr_decode(input logic [CR_WIDTH-1:0] b);
      cr_ctrl_t c;
      c.pri_en     = b[CR_PRI_EN_BIT];
      c.keep_run   = b[CR_KEEP_BIT];
      c.sec_en     = b[CR_SEC_EN_BIT];
      c.local_stop = b[CR_LOCAL_BIT];
      return c;
   endfunction

endpackage

// File: rtl/clkstop_pri_arb.sv
module clkstop_pri_arb #(
   parameter int DRIVE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic keep_run,
   input  logic pri_idle,
   input  logic pri_req_pend,
   input  logic line_in,
   output logic drive_low,
   output logic stop_granted
);
   localparam int CW = $clog2(DRIVE_CYC + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(DRIVE_CYC);

   generate
      if (DRIVE_CYC < 1) begin : g_bad_drive
         $error("clkstop_pri_arb: DRIVE_CYC must be at least 1");
      end
   endgenerate

   logic          line_q;
   logic [CW-1:0] drv_cnt;
   logic          stop_q;
   logic          req_rise;
   logic          refuse;

   // The line idles high, so the reset value avoids a false request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_in;
   end

   assign req_rise = line_in & ~line_q;
   assign refuse   = keep_run | ~pri_idle | pri_req_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_cnt <= '0;
      end else if (!en) begin
         drv_cnt <= '0;
      end else if (req_rise && refuse) begin
         drv_cnt <= CNT_LOAD;
      end else if (drv_cnt != '0) begin
         drv_cnt <= drv_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
      end else if (!en) begin
         stop_q <= 1'b0;
      end else if (req_rise && !refuse) begin
         stop_q <= 1'b1;
      end else if (!line_in) begin
         stop_q <= 1'b0;
      end
   end

   assign drive_low    = en & (drv_cnt != '0);
   assign stop_granted = stop_q;

endmodule

// File: rtl/clkstop_idle_timer.sv
module clkstop_idle_timer #(
   parameter int IDLE_MIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic quiet,
   output logic idle_ok
);
   localparam int TW = $clog2(IDLE_MIN + 1);
   localparam logic [TW-1:0] T_SAT = TW'(IDLE_MIN);

   generate
      if (IDLE_MIN < 1) begin : g_bad_idle
         $error("clkstop_idle_timer: IDLE_MIN must be at least 1");
      end
   endgenerate

   logic [TW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!quiet) begin
         run_cnt <= '0;
      end else if (run_cnt != T_SAT) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign idle_ok = (run_cnt == T_SAT);

endmodule

// File: rtl/clkstop_sec_gate.sv
module clkstop_sec_gate #(
   parameter bit ALLOW_LOCAL_STOP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic local_stop,
   input  logic pri_stopped,
   input  logic idle_ok,
   input  logic quiet,
   input  logic dn_pending,
   input  logic sec_line,
   output logic clk_en,
   output logic wake
);
   import clkstop_pkg::*;

   sg_state_e state_q;
   logic      policy_ok;
   logic      restart;
   logic      may_stop;

   generate
      if (ALLOW_LOCAL_STOP) begin : g_two_policy
         assign policy_ok = local_stop | pri_stopped;
      end else begin : g_follow_only
         logic unused_local;
         assign unused_local = local_stop;
         assign policy_ok    = pri_stopped;
      end
   endgenerate

   assign restart  = dn_pending | ~sec_line;
   assign may_stop = idle_ok & quiet & policy_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SG_RUN;
      end else if (!en) begin
         state_q <= SG_RUN;
      end else begin
         unique case (state_q)
            SG_RUN:   if (may_stop && !restart) state_q <= SG_GATED;
            SG_GATED: if (restart)              state_q <= SG_RUN;
            default:                            state_q <= SG_RUN;
         endcase
      end
   end

   // Disable lifts the gate in the same cycle; the edge only tidies state.
   assign clk_en = ~(en & (state_q == SG_GATED));
   assign wake   = en & (state_q == SG_GATED) & ~sec_line;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
   parameter int DRIVE_CYC        = 2,
   parameter int IDLE_MIN         = 4,
   parameter bit ALLOW_LOCAL_STOP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] ctrl_byte,
   input  logic       pri_idle,
   input  logic       pri_req_pend,
   input  logic       sec_idle,
   input  logic       pri_clkrun_in,
   input  logic       sec_clkrun_in,
   output logic       pri_clkrun_oe,
   output logic       sec_clk_en,
   output logic       sec_wake
);
   import clkstop_pkg::*;

   cr_ctrl_t ctl;
   logic     pri_stopped;
   logic     quiet;
   logic     idle_ok;

   assign ctl   = cr_decode(ctrl_byte);
   assign quiet = sec_idle & ~pri_req_pend & sec_clkrun_in;

   clkstop_pri_arb #(.DRIVE_CYC(DRIVE_CYC)) u_pri (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (ctl.pri_en),
      .keep_run     (ctl.keep_run),
      .pri_idle     (pri_idle),
      .pri_req_pend (pri_req_pend),
      .line_in      (pri_clkrun_in),
      .drive_low    (pri_clkrun_oe),
      .stop_granted (pri_stopped)
   );

   clkstop_idle_timer #(.IDLE_MIN(IDLE_MIN)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .quiet   (quiet),
      .idle_ok (idle_ok)
   );

   clkstop_sec_gate #(.ALLOW_LOCAL_STOP(ALLOW_LOCAL_STOP)) u_sec (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (ctl.sec_en),
      .local_stop  (ctl.local_stop),
      .pri_stopped (pri_stopped),
      .idle_ok     (idle_ok),
      .quiet       (quiet),
      .dn_pending  (pri_req_pend),
      .sec_line    (sec_clkrun_in),
      .clk_en      (sec_clk_en),
      .wake        (sec_wake)
   );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
   parameter int DRIVE_CYC = 2,
   parameter int IDLE_MIN  = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] ctrl_byte,
   input logic       pri_idle,
   input logic       pri_req_pend,
   input logic       sec_idle,
   input logic       pri_clkrun_in,
   input logic       sec_clkrun_in,
   input logic       pri_clkrun_oe,
   input logic       sec_clk_en,
   input logic       sec_wake
);
   logic armed;
   int   oe_run;
   int   q_run;
   logic quiet_c;

   assign quiet_c = sec_idle & ~pri_req_pend & sec_clkrun_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         oe_run <= 0;
         q_run  <= 0;
      end else begin
         armed  <= 1'b1;
         oe_run <= pri_clkrun_oe ? oe_run + 1 : 0;
         q_run  <= !quiet_c ? 0 : ((q_run > IDLE_MIN) ? q_run : q_run + 1);
      end
   end

   AST_OE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[3] |-> !pri_clkrun_oe); // R2

   AST_GRANT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ctrl_byte[3] && !ctrl_byte[2] && pri_idle && !pri_req_pend
       && pri_clkrun_in && !$past(pri_clkrun_in)) |=> !pri_clkrun_oe); // R3

   AST_DRIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      oe_run <= DRIVE_CYC); // R4

   AST_KEEP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ctrl_byte[3] && ctrl_byte[2] && pri_clkrun_in && !$past(pri_clkrun_in)
       && $stable(ctrl_byte)) |=> (pri_clkrun_oe || !ctrl_byte[3])); // R5

   AST_PEND_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      pri_req_pend |=> sec_clk_en); // R9

   AST_LINE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_clkrun_in |=> sec_clk_en); // R10

   AST_WAKE_ONLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      sec_wake |-> (!sec_clk_en && !sec_clkrun_in)); // R10

   AST_UNGATED_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[1] |-> sec_clk_en); // R11

   AST_GATE_AFTER_IDLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sec_clk_en) |-> (q_run > IDLE_MIN)); // R12

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.DRIVE_CYC(DRIVE_CYC), .IDLE_MIN(IDLE_MIN)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctrl_byte     (ctrl_byte),
   .pri_idle      (pri_idle),
   .pri_req_pend  (pri_req_pend),
   .sec_idle      (sec_idle),
   .pri_clkrun_in (pri_clkrun_in),
   .sec_clkrun_in (sec_clkrun_in),
   .pri_clkrun_oe (pri_clkrun_oe),
   .sec_clk_en    (sec_clk_en),
   .sec_wake      (sec_wake)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
   localparam int DRV  = 2;
   localparam int IMIN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctrl_byte = 8'h00;
   logic       pri_idle = 1'b1, pri_req_pend = 1'b0, sec_idle = 1'b1;
   logic       central_stop = 1'b0, sec_line = 1'b1;
   logic       pri_line;
   logic       pri_clkrun_oe, sec_clk_en, sec_wake;

   int n_chk = 0, n_fail = 0;
   bit started = 0;

   always #5 clk = ~clk;

   assign pri_line = central_stop & ~pri_clkrun_oe;

   clkstop_ctrl #(.DRIVE_CYC(DRV), .IDLE_MIN(IMIN)) i_clkstop_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte),
      .pri_idle(pri_idle), .pri_req_pend(pri_req_pend), .sec_idle(sec_idle),
      .pri_clkrun_in(pri_line), .sec_clkrun_in(sec_line),
      .pri_clkrun_oe(pri_clkrun_oe), .sec_clk_en(sec_clk_en), .sec_wake(sec_wake)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model of the requirements, advanced every clock edge.
   logic m_prev, m_stop, m_gated;
   int   m_cnt, m_icnt;

   function automatic logic f_refuse(input logic keep, input logic idle, input logic pend);
      return keep | ~idle | pend;
   endfunction

   function automatic logic f_quiet(input logic sidle, input logic pend, input logic sl);
      return sidle & ~pend & sl;
   endfunction

   always @(posedge clk) begin
      logic pen, keep, sen, lb, edge_r, rf, q, wk, m_oe;
      if (!rst_n) begin
         m_prev = 1'b1; m_stop = 1'b0; m_gated = 1'b0; m_cnt = 0; m_icnt = 0;
      end else if (started) begin
         pen = ctrl_byte[3]; keep = ctrl_byte[2]; sen = ctrl_byte[1]; lb = ctrl_byte[0];
         m_oe = pen && (m_cnt != 0);
         chk("R4 drive", pri_clkrun_oe, m_oe);
         chk("R7 gate", sec_clk_en, !(sen && m_gated));
         chk("R10 wake", sec_wake, sen && m_gated && !sec_line);
         edge_r = pri_line && !m_prev;
         rf = f_refuse(keep, pri_idle, pri_req_pend);
         q  = f_quiet(sec_idle, pri_req_pend, sec_line);
         wk = pri_req_pend || !sec_line;
         if (!sen) m_gated = 1'b0;
         else if (m_gated && wk) m_gated = 1'b0;
         else if (!m_gated && !wk && m_icnt == IMIN && q && (lb || m_stop)) m_gated = 1'b1;
         if (!pen) m_cnt = 0;
         else if (edge_r && rf) m_cnt = DRV;
         else if (m_cnt != 0) m_cnt = m_cnt - 1;
         if (!pen) m_stop = 1'b0;
         else if (edge_r && !rf) m_stop = 1'b1;
         else if (!pri_line) m_stop = 1'b0;
         if (!q) m_icnt = 0; else if (m_icnt < IMIN) m_icnt = m_icnt + 1;
         m_prev = pri_line;
      end
   end

   task automatic nx(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      nx(3);
      rst_n = 1'b1;
      nx(1);
      started = 1;
      chk("R1 oe", pri_clkrun_oe, 1'b0);
      chk("R1 clk_en", sec_clk_en, 1'b1);
      chk("R1 wake", sec_wake, 1'b0);

      // R2 / R11: all disabled, busy primary, quiet secondary.
      pri_idle = 1'b0; central_stop = 1'b0; nx(2); central_stop = 1'b1;
      for (int i = 0; i < 10; i++) begin
         nx(1); #1;
         chk("R2 no drive", pri_clkrun_oe, 1'b0);
         chk("R11 no gate", sec_clk_en, 1'b1);
      end

      // R4 / R6 / R3: refusal pulses, then grant once idle.
      ctrl_byte = 8'h08; central_stop = 1'b0; nx(3); central_stop = 1'b1;
      nx(1); chk("R4 first", pri_clkrun_oe, 1'b1);
      nx(1); chk("R4 second", pri_clkrun_oe, 1'b1);
      nx(1); chk("R4 released", pri_clkrun_oe, 1'b0);
      nx(1); chk("R6 refused again", pri_clkrun_oe, 1'b1);
      pri_idle = 1'b1;
      nx(1); chk("R4 hold", pri_clkrun_oe, 1'b1);
      nx(1); chk("R4 release", pri_clkrun_oe, 1'b0);
      nx(1); chk("R3 granted", pri_clkrun_oe, 1'b0);
      nx(1); chk("R3 still granted", pri_clkrun_oe, 1'b0);

      // R5: keep-running refuses an otherwise grantable request.
      ctrl_byte = 8'h0C; central_stop = 1'b0; nx(3); central_stop = 1'b1;
      nx(1); chk("R5 keep refuses", pri_clkrun_oe, 1'b1);

      // R7 / R9 / R12 / R10: following policy.
      ctrl_byte = 8'h0A; central_stop = 1'b0; nx(8);
      chk("R7 no stop without grant", sec_clk_en, 1'b1);
      central_stop = 1'b1;
      nx(1); chk("R7 grant edge", sec_clk_en, 1'b1);
      nx(1); chk("R7 gated", sec_clk_en, 1'b0);
      pri_req_pend = 1'b1;
      nx(1); chk("R9 restart", sec_clk_en, 1'b1);
      pri_req_pend = 1'b0;
      nx(4); chk("R12 not yet", sec_clk_en, 1'b1);
      nx(1); chk("R12 gated after run", sec_clk_en, 1'b0);
      sec_line = 1'b0; #1;
      chk("R10 wake sensed", sec_wake, 1'b1);
      nx(1); chk("R10 restart", sec_clk_en, 1'b1);

      // R8 / R11: local policy with primary clock running.
      ctrl_byte = 8'h0B; central_stop = 1'b0; sec_line = 1'b1;
      nx(4); chk("R8 not yet", sec_clk_en, 1'b1);
      nx(1); chk("R8 gated locally", sec_clk_en, 1'b0);
      ctrl_byte = 8'h09; #1;
      chk("R11 disable ungates", sec_clk_en, 1'b1);

      // Random phase, checked by the model every edge.
      void'($urandom(32'h5eed_c10c));
      for (int i = 0; i < 6000; i++) begin
         nx(1);
         if ($urandom_range(199) == 0) ctrl_byte = 8'($urandom_range(15));
         if ($urandom_range(15) == 0) central_stop = ~central_stop;
         pri_idle     = ($urandom_range(3) != 0);
         pri_req_pend = ($urandom_range(9) == 0);
         sec_idle     = ($urandom_range(5) != 0);
         sec_line     = ($urandom_range(31) != 0);
      end
      nx(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule